// File: doc/BRIEF.md
# Host Word Stream to DMA Feeder

This block lets a 16-bit host processor push a stream of halfwords into a small FIFO. A DMA channel owned by a second processor then empties the FIFO into a destination address range. The host programs a transfer length and sets an enable bit in a control register. It then writes words one at a time to a data port. The channel side supplies a destination address, a 24-bit transfer count, a mode field and a global DMA enable.

The FIFO is only ever drained as whole groups of four words. When the buffered word count is a non-zero multiple of four, the channel mode equals 1 and the global DMA enable is high, the block drains every buffered word in order through a valid/ready write port. Each accepted word moves the destination address up by 2, and decrements both the channel count and the host length. Two separate completion indications result. The host enable bit drops when the host length is exhausted. The channel's transfer-end flag rises when the channel count is exhausted.

Top module: `host_dma_feeder`

## Requirements
- R1: After reset the control register reads 0, the length register reads 0, the channel count is 0, the transfer-end flag is 0, the FIFO is not full and wrValid is 0.
- R2: A host write to the length register (hostAddr 1) stores the written value with bits 1:0 forced to zero.
- R3: A write to the FIFO data port (hostAddr 2) is ignored while the host enable bit (control bit 2) is clear.
- R4: The FIFO holds DEPTH words. fifoFull and control bit 7 rise when the count reaches DEPTH, and data-port writes while full are ignored.
- R5: Draining starts only when the buffered count is a non-zero multiple of four, chanMode equals 1 and dmaEnable is high. Otherwise no word is presented.
- R6: Drained words leave in write order. Each accepted word goes to the current destination address. The address then rises by 2, the channel count falls by 1, and the host length falls by 1 unless it is already 0.
- R7: When a drain ends, the FIFO is empty and the full flag is clear. The host enable bit clears if the host length is 0 at that point, and stays set otherwise.
- R8: A drain stops when the channel count reaches 0. The remaining buffered words are discarded and chanEnd is set. chanEnd stays set until the next channel load (chanLoad), which clears it.
- R9: Host writes to the control register (hostAddr 0) affect only bits 2:0 (bit 0 region select, bit 1 DMA request, bit 2 enable). Bit 7, the full flag, is preserved, and every other bit reads 0.
- R10: While wrValid is high and wrReady is low, wrValid, wrAddr and wrData hold their values.
- R11: Data-port writes that arrive while a drain is in progress, or in the cycle one is being started, are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 2 | Register select: 0 control, 1 length, 2 FIFO data |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Read data of the selected register (FIFO port reads 0) |
| chanLoad | input | 1 | Loads destination address and channel count, clears chanEnd |
| chanDstIn | input | ADDR_W | Destination start address |
| chanCountIn | input | CHAN_W | Channel transfer count to load |
| chanMode | input | 2 | Channel mode field; value 1 permits draining |
| dmaEnable | input | 1 | Global DMA enable |
| wrValid | output | 1 | Write master request |
| wrReady | input | 1 | Destination accepts the word |
| wrAddr | output | ADDR_W | Write address |
| wrData | output | 16 | Write data |
| fifoFull | output | 1 | FIFO full status |
| xferEnable | output | 1 | Host enable bit |
| xferLen | output | 16 | Remaining host length |
| chanCount | output | CHAN_W | Remaining channel count |
| chanEnd | output | 1 | Channel transfer-end flag |

## Verification
Register writes become visible on hostRdata and the status outputs at the first clock edge after the write. A drain enters its busy state at the edge after the push that completes a group. wrValid is therefore first seen one cycle after that push, one word leaves per cycle that wrReady is high, and the FIFO is cleared one cycle after the last accepted word. The bench drives inputs one time unit after the rising edge and samples at the falling edge. A monitor records every accepted write at the falling edge, and the scenarios inspect that log after a fixed margin of cycles that is well past the longest expected drain. Negative cases (no drain, dropped words) are checked by observing that the log does not grow and that a later group drains with exactly the expected data.

// File: rtl/feeder_pkg.sv
package feeder_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LEN  = 2'd1;
  localparam logic [1:0] ADDR_FIFO = 2'd2;
  localparam logic [1:0] MODE_DRAIN = 2'd1;

  typedef enum logic {ST_IDLE, ST_DRAIN} drainState_t;

  typedef struct packed {
    logic busy;     // drain active or starting: block pushes
    logic popWord;  // one word accepted by destination
    logic finish;   // drain over: empty FIFO, update completion
  } drainStrobes_t;
endpackage

// File: rtl/feeder_datapath.sv
module feeder_datapath
  import feeder_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int CHAN_W = 24,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWe,
  input  logic [1:0]          hostAddr,
  input  logic [15:0]         hostWdata,
  output logic [15:0]         hostRdata,
  input  logic                chanLoad,
  input  logic [ADDR_W-1:0]   chanDstIn,
  input  logic [CHAN_W-1:0]   chanCountIn,
  input  drainStrobes_t       strb,
  output logic [CNT_W-1:0]    fifoCnt,
  output logic                wordAvail,
  output logic [ADDR_W-1:0]   wrAddr,
  output logic [15:0]         wrData,
  output logic                fifoFull,
  output logic                xferEnable,
  output logic [15:0]         xferLen,
  output logic [CHAN_W-1:0]   chanCount,
  output logic                chanEnd
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [15:0]       mem [DEPTH];
  logic [CNT_W-1:0]  cnt, rdIdx;
  logic              fullFlag, ctrlRv, ctrlDma, ctrlEn;
  logic [15:0]       lenReg;
  logic [ADDR_W-1:0] dstAddr;
  logic [CHAN_W-1:0] chanCnt;
  logic              endFlag;
  logic              pushOk;

  assign pushOk = hostWe && (hostAddr == ADDR_FIFO) && ctrlEn && !fullFlag && !strb.busy;

  always_ff @(posedge clk) begin
    if (pushOk) mem[cnt[PTR_W-1:0]] <= hostWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      rdIdx    <= '0;
      fullFlag <= 1'b0;
      ctrlRv   <= 1'b0;
      ctrlDma  <= 1'b0;
      ctrlEn   <= 1'b0;
      lenReg   <= '0;
      dstAddr  <= '0;
      chanCnt  <= '0;
      endFlag  <= 1'b0;
    end else begin
      if (pushOk) begin
        cnt <= cnt + CNT_W'(1);
        if (cnt == CNT_W'(DEPTH - 1)) fullFlag <= 1'b1;
      end
      if (strb.popWord) begin
        rdIdx   <= rdIdx + CNT_W'(1);
        dstAddr <= dstAddr + ADDR_W'(2);
        chanCnt <= chanCnt - CHAN_W'(1);
        if (lenReg != 16'd0) lenReg <= lenReg - 16'd1;
      end
      if (strb.finish) begin
        cnt      <= '0;
        rdIdx    <= '0;
        fullFlag <= 1'b0;
        if (lenReg == 16'd0) ctrlEn <= 1'b0;
        if (chanCnt == '0) endFlag <= 1'b1;
      end
      if (hostWe && hostAddr == ADDR_LEN) lenReg <= {hostWdata[15:2], 2'b00};
      if (hostWe && hostAddr == ADDR_CTRL) begin
        ctrlRv  <= hostWdata[0];
        ctrlDma <= hostWdata[1];
        ctrlEn  <= hostWdata[2];
      end
      if (chanLoad) begin
        dstAddr <= chanDstIn;
        chanCnt <= chanCountIn;
        endFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    case (hostAddr)
      ADDR_CTRL: hostRdata = {8'h00, fullFlag, 4'b0000, ctrlEn, ctrlDma, ctrlRv};
      ADDR_LEN:  hostRdata = lenReg;
      default:   hostRdata = 16'h0000;
    endcase
  end

  assign fifoCnt    = cnt;
  assign wordAvail  = (rdIdx < cnt) && (chanCnt != '0);
  assign wrAddr     = dstAddr;
  assign wrData     = mem[rdIdx[PTR_W-1:0]];
  assign fifoFull   = fullFlag;
  assign xferEnable = ctrlEn;
  assign xferLen    = lenReg;
  assign chanCount  = chanCnt;
  assign chanEnd    = endFlag;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN) cnt <= CNT_W'(DEPTH)); // R4
  AST_FULL_TRACKS: assert property (@(posedge clk) disable iff (!rstN) fullFlag == (cnt == CNT_W'(DEPTH))); // R4
  AST_PUSH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN) !ctrlEn |=> cnt <= $past(cnt)); // R3
  AST_NO_PUSH_BUSY: assert property (@(posedge clk) disable iff (!rstN) strb.busy |=> cnt <= $past(cnt)); // R11
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN) (strb.popWord && !chanLoad) |=> dstAddr == $past(dstAddr) + ADDR_W'(2)); // R6
  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN) $rose(endFlag) |-> chanCnt == '0); // R8
endmodule

// File: rtl/feeder_control.sv
module feeder_control
  import feeder_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCnt,
  input  logic             wordAvail,
  input  logic [1:0]       chanMode,
  input  logic             dmaEnable,
  input  logic             wrReady,
  output logic             wrValid,
  output drainStrobes_t    strb
);
  drainState_t state;
  logic        trigger, draining;

  assign draining = (state == ST_DRAIN);
  assign trigger  = (state == ST_IDLE) && (fifoCnt != '0) && (fifoCnt[1:0] == 2'b00)
                    && (chanMode == MODE_DRAIN) && dmaEnable;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else if (trigger) state <= ST_DRAIN;
    else if (draining && !wordAvail) state <= ST_IDLE;
  end

  assign wrValid      = draining && wordAvail;
  assign strb.busy    = draining || trigger;
  assign strb.popWord = wrValid && wrReady;
  assign strb.finish  = draining && !wordAvail;

  AST_GROUP_START: assert property (@(posedge clk) disable iff (!rstN) $rose(draining) |-> (fifoCnt != '0 && fifoCnt[1:0] == 2'b00)); // R5
endmodule

// File: rtl/host_dma_feeder.sv
module host_dma_feeder
  import feeder_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int CHAN_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [1:0]        hostAddr,
  input  logic [15:0]       hostWdata,
  output logic [15:0]       hostRdata,
  input  logic              chanLoad,
  input  logic [ADDR_W-1:0] chanDstIn,
  input  logic [CHAN_W-1:0] chanCountIn,
  input  logic [1:0]        chanMode,
  input  logic              dmaEnable,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [15:0]       wrData,
  output logic              fifoFull,
  output logic              xferEnable,
  output logic [15:0]       xferLen,
  output logic [CHAN_W-1:0] chanCount,
  output logic              chanEnd
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  drainStrobes_t    strb;
  logic [CNT_W-1:0] fifoCnt;
  logic             wordAvail;

  feeder_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .chanLoad(chanLoad), .chanDstIn(chanDstIn), .chanCountIn(chanCountIn),
    .strb(strb), .fifoCnt(fifoCnt), .wordAvail(wordAvail), .wrAddr(wrAddr), .wrData(wrData),
    .fifoFull(fifoFull), .xferEnable(xferEnable), .xferLen(xferLen), .chanCount(chanCount),
    .chanEnd(chanEnd)
  );

  feeder_control #(.CNT_W(CNT_W)) i_control (
    .clk(clk), .rstN(rstN), .fifoCnt(fifoCnt), .wordAvail(wordAvail), .chanMode(chanMode),
    .dmaEnable(dmaEnable), .wrReady(wrReady), .wrValid(wrValid), .strb(strb)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData))); // R10
endmodule

// File: tb/test_host_dma_feeder.sv
`timescale 1ns/1ps
module test_host_dma_feeder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [15:0] hostWdata = 16'h0;
  logic [15:0] hostRdata;
  logic        chanLoad = 1'b0;
  logic [31:0] chanDstIn = 32'h0;
  logic [23:0] chanCountIn = 24'h0;
  logic [1:0]  chanMode = 2'd0;
  logic        dmaEnable = 1'b0;
  logic        wrValid;
  logic        wrReady = 1'b1;
  logic [31:0] wrAddr;
  logic [15:0] wrData;
  logic        fifoFull, xferEnable, chanEnd;
  logic [15:0] xferLen;
  logic [23:0] chanCount;

  int checks = 0;
  int errors = 0;
  int capN = 0;
  logic [31:0] capAddr [64];
  logic [15:0] capData [64];

  always #4 clk = ~clk;

  host_dma_feeder i_host_dma_feeder (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .chanLoad(chanLoad), .chanDstIn(chanDstIn), .chanCountIn(chanCountIn),
    .chanMode(chanMode), .dmaEnable(dmaEnable), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData), .fifoFull(fifoFull), .xferEnable(xferEnable),
    .xferLen(xferLen), .chanCount(chanCount), .chanEnd(chanEnd)
  );

  always @(negedge clk) begin
    if (rstN && wrValid && wrReady && capN < 64) begin
      capAddr[capN] = wrAddr;
      capData[capN] = wrData;
      capN++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(posedge clk); #1;
    hostWe = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    hostAddr = a;
    @(negedge clk);
    d = hostRdata;
  endtask

  task automatic loadChan(input logic [31:0] dst, input logic [23:0] n);
    @(posedge clk); #1;
    chanLoad = 1'b1; chanDstIn = dst; chanCountIn = n;
    @(posedge clk); #1;
    chanLoad = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkLog(input string tag, input int base, input int n,
                          input logic [31:0] addr0, input logic [15:0] data0);
    for (int i = 0; i < n; i++) begin
      chk(tag, capAddr[base + i], addr0 + 32'(2 * i));
      chk(tag, {16'h0, capData[base + i]}, {16'h0, data0 + 16'(i)});
    end
  endtask

  task automatic testReset();
    logic [15:0] d;
    readReg(2'd0, d); chk("R1 ctrl", {16'h0, d}, 32'h0);
    readReg(2'd1, d); chk("R1 len", {16'h0, d}, 32'h0);
    chk("R1 wrValid", {31'h0, wrValid}, 32'h0);
    chk("R1 fifoFull", {31'h0, fifoFull}, 32'h0);
    chk("R1 chanEnd", {31'h0, chanEnd}, 32'h0);
    chk("R1 chanCount", {8'h0, chanCount}, 32'h0);
  endtask

  task automatic testRegs();
    logic [15:0] d;
    hostWrite(2'd1, 16'h0013); readReg(2'd1, d); chk("R2 len mask", {16'h0, d}, 32'h0010);
    hostWrite(2'd1, 16'hFFFF); readReg(2'd1, d); chk("R2 len mask", {16'h0, d}, 32'hFFFC);
    hostWrite(2'd0, 16'hFFFF); readReg(2'd0, d); chk("R9 ctrl bits", {16'h0, d}, 32'h0007);
    chk("R9 full untouched", {31'h0, fifoFull}, 32'h0);
    hostWrite(2'd0, 16'h0000); readReg(2'd0, d); chk("R9 ctrl clear", {16'h0, d}, 32'h0000);
  endtask

  task automatic testIgnoredAndNormal();
    int base;
    loadChan(32'h1000, 24'd100);
    chanMode = 2'd1; dmaEnable = 1'b1;
    base = capN;
    for (int i = 0; i < 4; i++) hostWrite(2'd2, 16'hA000 + 16'(i));
    idle(12);
    chk("R3 disabled push ignored", capN - base, 0);
    hostWrite(2'd0, 16'h0004);
    hostWrite(2'd1, 16'h0008);
    for (int i = 0; i < 3; i++) hostWrite(2'd2, 16'h1111 * 16'(i + 1));
    idle(12);
    chk("R5 three words no drain", capN - base, 0);
    chk("R5 wrValid low", {31'h0, wrValid}, 32'h0);
    hostWrite(2'd2, 16'h4444);
    idle(12);
    chk("R6 group count", capN - base, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R6 addr", capAddr[base + i], 32'h1000 + 32'(2 * i));
      chk("R6 data", {16'h0, capData[base + i]}, {16'h0, 16'h1111 * 16'(i + 1)});
    end
    chk("R6 chanCount", {8'h0, chanCount}, 32'd96);
    chk("R6 len", {16'h0, xferLen}, 32'd4);
    chk("R7 enable kept", {31'h0, xferEnable}, 32'h1);
    base = capN;
    for (int i = 0; i < 4; i++) hostWrite(2'd2, 16'h5000 + 16'(i));
    idle(12);
    chk("R6 second group count", capN - base, 4);
    checkLog("R6 second group", base, 4, 32'h1008, 16'h5000);
    chk("R6 chanCount", {8'h0, chanCount}, 32'd92);
    chk("R7 len zero", {16'h0, xferLen}, 32'd0);
    chk("R7 enable cleared", {31'h0, xferEnable}, 32'h0);
    chk("R8 no end yet", {31'h0, chanEnd}, 32'h0);
  endtask

  task automatic testFullAndGating();
    int base;
    logic [15:0] d;
    chanMode = 2'd2; dmaEnable = 1'b1;
    hostWrite(2'd0, 16'h0004);
    hostWrite(2'd1, 16'h0010);
    base = capN;
    for (int i = 0; i < 4; i++) hostWrite(2'd2, 16'h6000 + 16'(i));
    idle(12);
    chk("R5 mode 2 blocks drain", capN - base, 0);
    @(posedge clk); #1; chanMode = 2'd1; dmaEnable = 1'b0;
    idle(12);
    chk("R5 dma off blocks drain", capN - base, 0);
    for (int i = 4; i < 8; i++) hostWrite(2'd2, 16'h6000 + 16'(i));
    idle(2);
    chk("R4 full set", {31'h0, fifoFull}, 32'h1);
    hostWrite(2'd2, 16'h7777);
    hostWrite(2'd0, 16'h0004);
    readReg(2'd0, d);
    chk("R9 full preserved", {16'h0, d}, 32'h0084);
    @(posedge clk); #1; dmaEnable = 1'b1;
    idle(16);
    chk("R4 only depth words", capN - base, 8);
    checkLog("R4 drained data", base, 8, 32'h1010, 16'h6000);
    chk("R7 full cleared", {31'h0, fifoFull}, 32'h0);
    chk("R7 len", {16'h0, xferLen}, 32'd8);
    chk("R7 enable kept", {31'h0, xferEnable}, 32'h1);
    chk("R6 chanCount", {8'h0, chanCount}, 32'd84);
  endtask

  task automatic testStall();
    int base;
    logic [31:0] a0;
    logic [15:0] d0;
    base = capN;
    @(posedge clk); #1; wrReady = 1'b0;
    for (int i = 0; i < 4; i++) hostWrite(2'd2, 16'h8000 + 16'(i));
    idle(3);
    chk("R10 valid while stalled", {31'h0, wrValid}, 32'h1);
    a0 = wrAddr; d0 = wrData;
    chk("R10 first addr", a0, 32'h1020);
    chk("R10 first data", {16'h0, d0}, 32'h8000);
    idle(2);
    chk("R10 valid held", {31'h0, wrValid}, 32'h1);
    chk("R10 addr held", wrAddr, a0);
    chk("R10 data held", {16'h0, wrData}, {16'h0, d0});
    hostWrite(2'd2, 16'h9999);
    @(posedge clk); #1; wrReady = 1'b1;
    idle(12);
    chk("R10 group after stall", capN - base, 4);
    checkLog("R10 order", base, 4, 32'h1020, 16'h8000);
    base = capN;
    for (int i = 0; i < 3; i++) hostWrite(2'd2, 16'hB000 + 16'(i));
    idle(12);
    chk("R11 dropped word not counted", capN - base, 0);
    hostWrite(2'd2, 16'hB003);
    idle(12);
    chk("R11 next group", capN - base, 4);
    checkLog("R11 next data", base, 4, 32'h1028, 16'hB000);
    chk("R7 enable cleared at len 0", {31'h0, xferEnable}, 32'h0);
    chk("R6 chanCount", {8'h0, chanCount}, 32'd76);
  endtask

  task automatic testChannelEnd();
    int base;
    loadChan(32'h2000, 24'd2);
    chk("R8 load clears end", {31'h0, chanEnd}, 32'h0);
    hostWrite(2'd0, 16'h0004);
    hostWrite(2'd1, 16'h000C);
    base = capN;
    for (int i = 0; i < 4; i++) hostWrite(2'd2, 16'hC000 + 16'(i));
    idle(12);
    chk("R8 stops at count", capN - base, 2);
    checkLog("R8 data", base, 2, 32'h2000, 16'hC000);
    chk("R8 count zero", {8'h0, chanCount}, 32'd0);
    chk("R8 end set", {31'h0, chanEnd}, 32'h1);
    chk("R8 len", {16'h0, xferLen}, 32'd10);
    chk("R8 fifo emptied", {31'h0, fifoFull}, 32'h0);
    base = capN;
    for (int i = 0; i < 4; i++) hostWrite(2'd2, 16'hD000 + 16'(i));
    idle(12);
    chk("R8 nothing with count 0", capN - base, 0);
    chk("R8 end sticky", {31'h0, chanEnd}, 32'h1);
    chk("R8 len unchanged", {16'h0, xferLen}, 32'd10);
    loadChan(32'h3000, 24'd4);
    idle(1);
    chk("R8 reload clears end", {31'h0, chanEnd}, 32'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testRegs();
    testIgnoredAndNormal();
    testFullAndGating();
    testStall();
    testChannelEnd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule